// File: doc/BRIEF.md
# Asynchronous SRAM Controller with Page Reads

This block sits between a simple synchronous request port and an external asynchronous static RAM of 128K words by 16 bits. A requester raises `req_i` while `ready_o` is high and supplies a direction flag, a word address, write data, two byte-lane enables and, for reads, a burst length. The controller then drives the memory pins in the required order. All memory timing is derived from picosecond parameters, each rounded up to whole clock cycles.

A single write holds the write strobe low for the longest of three windows: the strobe width, the data setup time, and the cycle time minus one. It then releases the strobe for one hold cycle. Reads can be bursts of up to 16 words. For a burst, the upper address bits (the page) and the chip enables stay fixed while the low four bits count upward, which puts the memory in its low-power page mode. A burst never crosses into the next page. It stops at the last word of the page, and the number of words actually delivered is reported.

Between operations the chip is left deselected. When the direction changes, from read to write or write to read, an extra bus-turnaround gap is inserted so that the two sides never drive the data bus at the same time.

Top module: `sram_page_ctrl`

## Requirements
- R1: While idle (`ready_o`=1), the chip is in standby: `mem_ce1_no`=1, `mem_ce2_o`=0, `mem_we_no`=1, `mem_oe_no`=1, both byte selects high and `mem_dq_oe_o`=0. This is also the reset state, with `rvalid_o`=0.
- R2: A write drives `mem_dq_o` with the request data and holds `mem_we_no` low for max(strobe, setup, cycle-1) cycles (17 at the defaults). During that time `mem_oe_no` stays high and the bus is driven, and the data stays driven for one further cycle after the strobe rises.
- R3: A single read returns the word present on `mem_dq_i` in the last cycle of the access window, as a one-cycle `rvalid_o` pulse with `rdata_o`.
- R4: `req_be_i[0]` enables lane 7..0 through `mem_lb_no` (low = selected), and `req_be_i[1]` enables lane 15..8 through `mem_ub_no`. A write with both enables at 0 changes no stored bit.
- R5: During a read burst, `mem_addr_o[16:4]` and the chip enables do not change. The low four bits step up by one per word, and data comes back in address order.
- R6: A burst delivers min(len, 16 - addr[3:0]) words. A length of 0 counts as 1 and a length above 16 counts as 16. The delivered count appears on `count_o` with `done_o`.
- R7: `ready_o` is low from the cycle after an accepted request until the operation finishes. Requests made while it is low are ignored.
- R8: When the direction changes, the chip is deselected for at least turnaround+1 cycles (6 at the defaults). `mem_oe_no` is never low while `mem_dq_oe_o` is 1, and never low in the cycle right after the controller drove the bus.
- R9: Each read word keeps `mem_oe_no` low for the full cycle-time count (18 cycles at the defaults). A burst of N words keeps it low for 18·N cycles without a break.
- R10: `done_o` pulses for one cycle at the end of each operation. For a read it coincides with the last `rvalid_o`, and for a write `count_o` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Request strobe, taken when `ready_o` is high |
| req_we_i | input | 1 | 1 = write, 0 = read |
| req_addr_i | input | 17 | Word address (start address for a burst) |
| req_wdata_i | input | 16 | Write data |
| req_be_i | input | 2 | Byte-lane enables, bit 1 = upper lane |
| req_len_i | input | 5 | Burst length in words, 1..16 |
| ready_o | output | 1 | Idle, can take a request |
| rvalid_o | output | 1 | One-cycle read data valid |
| rdata_o | output | 16 | Read data |
| done_o | output | 1 | Operation complete pulse |
| count_o | output | 5 | Words delivered, valid with `done_o` |
| mem_addr_o | output | 17 | Memory address |
| mem_ce1_no | output | 1 | Chip enable, active low |
| mem_ce2_o | output | 1 | Chip enable, active high |
| mem_we_no | output | 1 | Write strobe, active low |
| mem_oe_no | output | 1 | Output enable, active low |
| mem_ub_no | output | 1 | Upper byte select, active low |
| mem_lb_no | output | 1 | Lower byte select, active low |
| mem_dq_o | output | 16 | Data to the pad |
| mem_dq_oe_o | output | 1 | Pad driver enable |
| mem_dq_i | input | 16 | Data from the pad |

## Verification
Assertions check the following on every cycle:
- the standby pin state while idle;
- that the output enable and the controller's bus driver are never active together, and that there is always at least one cycle between the driver switching off and the output enable switching on;
- that the write strobe is never low while the output enable is;
- that the page bits do not move while the output enable stays low;
- that a burst never runs past the end of its page.

Only the bench scenarios can show the remaining behaviour:
- exact strobe and access widths;
- byte-lane merging against a memory model;
- burst contents, order and truncated counts;
- requests dropped while busy;
- the length of the deselected gap when the direction changes.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;
  typedef enum logic [2:0] {ST_IDLE, ST_TURN, ST_READ, ST_WRITE, ST_WHOLD} ctrl_state_e;

  function automatic int unsigned cdiv(input int unsigned num, input int unsigned den);
    return (num + den - 1) / den;
  endfunction
endpackage

// File: rtl/sram_cycle_timer.sv
module sram_cycle_timer #(
  parameter int unsigned W = 5
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] val_i,
  output logic         expired_o
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cnt_q <= '0;
    else if (load_i)          cnt_q <= val_i;
    else if (cnt_q != '0)     cnt_q <= cnt_q - 1'b1;
  end

  assign expired_o = (cnt_q == '0);
endmodule

// File: rtl/sram_page_walker.sv
module sram_page_walker #(
  parameter int unsigned AW = 17,
  parameter int unsigned WB = 4,
  localparam int unsigned LW = WB + 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic          step_i,
  input  logic [AW-1:0] addr_i,
  input  logic [LW-1:0] len_i,
  output logic [AW-1:0] addr_o,
  output logic          last_o,
  output logic [LW-1:0] count_o
);
  localparam logic [LW-1:0] PW_L  = LW'(1 << WB);
  localparam logic [LW-1:0] ONE_L = LW'(1);

  logic [AW-WB-1:0] page_q;
  logic [WB-1:0]    word_q;
  logic [LW-1:0]    remain_q, count_q;
  logic [LW-1:0]    len_eff, room, words;

  always_comb begin
    if (len_i == '0)      len_eff = ONE_L;
    else if (len_i > PW_L) len_eff = PW_L;
    else                  len_eff = len_i;
    room  = PW_L - {1'b0, addr_i[WB-1:0]};
    words = (len_eff < room) ? len_eff : room;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      page_q   <= '0;
      word_q   <= '0;
      remain_q <= '0;
      count_q  <= '0;
    end else if (load_i) begin
      page_q   <= addr_i[AW-1:WB];
      word_q   <= addr_i[WB-1:0];
      remain_q <= words;
      count_q  <= words;
    end else if (step_i) begin
      word_q   <= word_q + 1'b1;
      remain_q <= remain_q - 1'b1;
    end
  end

  assign addr_o  = {page_q, word_q};
  assign last_o  = (remain_q == ONE_L);
  assign count_o = count_q;

  AST_PAGE_NO_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (remain_q != '0) |-> (({1'b0, word_q} + remain_q) <= PW_L)); // R6
endmodule

// File: rtl/sram_page_ctrl.sv
module sram_page_ctrl import sram_ctrl_pkg::*; #(
  parameter int unsigned CLK_PS     = 4000,
  parameter int unsigned T_CYCLE_PS = 70000,
  parameter int unsigned T_WP_PS    = 40000,
  parameter int unsigned T_DW_PS    = 40000,
  parameter int unsigned T_TURN_PS  = 20000,
  parameter int unsigned AW         = 17,
  parameter int unsigned WB         = 4,
  localparam int unsigned DW        = 16,
  localparam int unsigned LW        = WB + 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          req_i,
  input  logic          req_we_i,
  input  logic [AW-1:0] req_addr_i,
  input  logic [DW-1:0] req_wdata_i,
  input  logic [1:0]    req_be_i,
  input  logic [LW-1:0] req_len_i,
  output logic          ready_o,
  output logic          rvalid_o,
  output logic [DW-1:0] rdata_o,
  output logic          done_o,
  output logic [LW-1:0] count_o,
  output logic [AW-1:0] mem_addr_o,
  output logic          mem_ce1_no,
  output logic          mem_ce2_o,
  output logic          mem_we_no,
  output logic          mem_oe_no,
  output logic          mem_ub_no,
  output logic          mem_lb_no,
  output logic [DW-1:0] mem_dq_o,
  output logic          mem_dq_oe_o,
  input  logic [DW-1:0] mem_dq_i
);
  localparam int unsigned RD_CYC = (cdiv(T_CYCLE_PS, CLK_PS) < 1) ? 1 : cdiv(T_CYCLE_PS, CLK_PS);
  localparam int unsigned WP_C   = cdiv(T_WP_PS, CLK_PS);
  localparam int unsigned DW_C   = cdiv(T_DW_PS, CLK_PS);
  localparam int unsigned WL_A   = (WP_C > DW_C) ? WP_C : DW_C;
  localparam int unsigned WL_B   = (WL_A > RD_CYC - 1) ? WL_A : RD_CYC - 1;
  localparam int unsigned WL_CYC = (WL_B < 1) ? 1 : WL_B;
  localparam int unsigned TA_CYC = (cdiv(T_TURN_PS, CLK_PS) < 1) ? 1 : cdiv(T_TURN_PS, CLK_PS);
  localparam int unsigned MX_A   = (RD_CYC > WL_CYC) ? RD_CYC : WL_CYC;
  localparam int unsigned MX_CYC = (MX_A > TA_CYC) ? MX_A : TA_CYC;
  localparam int unsigned TW     = $clog2(MX_CYC + 1);
  localparam logic [TW-1:0] RD_LAST = TW'(RD_CYC - 1);
  localparam logic [TW-1:0] WL_LAST = TW'(WL_CYC - 1);
  localparam logic [TW-1:0] TA_LAST = TW'(TA_CYC - 1);

  ctrl_state_e   state_q;
  logic          op_we_q, last_we_q, has_last_q;
  logic [DW-1:0] wdata_q, rdata_q;
  logic [1:0]    be_q;
  logic          rvalid_q, done_q;
  logic          t_load, t_exp;
  logic [TW-1:0] t_val;
  logic          w_load, w_step, w_last;
  logic          need_turn, sel;

  assign need_turn = has_last_q && (last_we_q != req_we_i);
  assign w_load    = (state_q == ST_IDLE) && req_i;
  assign w_step    = (state_q == ST_READ) && t_exp && !w_last;

  always_comb begin
    t_load = 1'b0;
    t_val  = '0;
    unique case (state_q)
      ST_IDLE: if (req_i) begin
        t_load = 1'b1;
        t_val  = need_turn ? TA_LAST : (req_we_i ? WL_LAST : RD_LAST);
      end
      ST_TURN: if (t_exp) begin
        t_load = 1'b1;
        t_val  = op_we_q ? WL_LAST : RD_LAST;
      end
      ST_READ: if (t_exp && !w_last) begin
        t_load = 1'b1;
        t_val  = RD_LAST;
      end
      default: ;
    endcase
  end

  sram_cycle_timer #(.W(TW)) u_timer (
    .clk_i, .rst_ni, .load_i(t_load), .val_i(t_val), .expired_o(t_exp)
  );

  sram_page_walker #(.AW(AW), .WB(WB)) u_walker (
    .clk_i, .rst_ni,
    .load_i (w_load),
    .step_i (w_step),
    .addr_i (req_addr_i),
    .len_i  (req_we_i ? LW'(1) : req_len_i),  // writes are single words
    .addr_o (mem_addr_o),
    .last_o (w_last),
    .count_o(count_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_IDLE;
      op_we_q    <= 1'b0;
      last_we_q  <= 1'b0;
      has_last_q <= 1'b0;
      wdata_q    <= '0;
      be_q       <= '0;
      rdata_q    <= '0;
      rvalid_q   <= 1'b0;
      done_q     <= 1'b0;
    end else begin
      rvalid_q <= 1'b0;
      done_q   <= 1'b0;
      unique case (state_q)
        ST_IDLE: if (req_i) begin
          op_we_q <= req_we_i;
          wdata_q <= req_wdata_i;
          be_q    <= req_be_i;
          state_q <= need_turn ? ST_TURN : (req_we_i ? ST_WRITE : ST_READ);
        end
        ST_TURN: if (t_exp) state_q <= op_we_q ? ST_WRITE : ST_READ;
        ST_READ: if (t_exp) begin
          rdata_q  <= mem_dq_i;
          rvalid_q <= 1'b1;
          if (w_last) begin
            state_q    <= ST_IDLE;
            done_q     <= 1'b1;
            last_we_q  <= 1'b0;
            has_last_q <= 1'b1;
          end
        end
        ST_WRITE: if (t_exp) state_q <= ST_WHOLD;
        ST_WHOLD: begin
          state_q    <= ST_IDLE;
          done_q     <= 1'b1;
          last_we_q  <= 1'b1;
          has_last_q <= 1'b1;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign sel         = (state_q == ST_READ) || (state_q == ST_WRITE) || (state_q == ST_WHOLD);
  assign ready_o     = (state_q == ST_IDLE);
  assign rvalid_o    = rvalid_q;
  assign rdata_o     = rdata_q;
  assign done_o      = done_q;
  assign mem_ce1_no  = !sel;
  assign mem_ce2_o   = sel;
  assign mem_oe_no   = (state_q != ST_READ);
  assign mem_we_no   = (state_q != ST_WRITE);
  assign mem_ub_no   = !(sel && be_q[1]);
  assign mem_lb_no   = !(sel && be_q[0]);
  assign mem_dq_o    = wdata_q;
  assign mem_dq_oe_o = (state_q == ST_WRITE) || (state_q == ST_WHOLD);

  AST_IDLE_STANDBY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o |-> (mem_ce1_no && !mem_ce2_o && mem_we_no && !mem_dq_oe_o)); // R1
  AST_WE_BLOCKS_OE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mem_we_no |-> (mem_oe_no && mem_dq_oe_o)); // R2
  AST_NO_CONTENTION: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mem_oe_no |-> !mem_dq_oe_o); // R8
  AST_BUS_RELEASE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mem_oe_no |-> !$past(mem_dq_oe_o)); // R8
  AST_PAGE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!mem_oe_no && !$past(mem_oe_no)) |-> (mem_addr_o[AW-1:WB] == $past(mem_addr_o[AW-1:WB]))); // R5
  AST_DONE_WITH_READ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !$past(op_we_q)) |-> rvalid_o); // R10
endmodule

// File: tb/sram_page_ctrl_test.sv
module sram_page_ctrl_test;
  localparam int RD = 18;
  localparam int WL = 17;
  localparam int TA = 5;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0, req_we = 1'b0;
  logic [16:0] req_addr = '0;
  logic [15:0] req_wdata = '0;
  logic [1:0]  req_be = '0;
  logic [4:0]  req_len = '0;
  logic        ready_o, rvalid_o, done_o;
  logic [15:0] rdata_o;
  logic [4:0]  count_o;
  logic [16:0] mem_addr_o;
  logic        mem_ce1_no, mem_ce2_o, mem_we_no, mem_oe_no, mem_ub_no, mem_lb_no, mem_dq_oe_o;
  logic [15:0] mem_dq_o, mem_dq_i;

  always #2 clk = ~clk;

  sram_page_ctrl uut (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .req_we_i(req_we), .req_addr_i(req_addr),
    .req_wdata_i(req_wdata), .req_be_i(req_be), .req_len_i(req_len),
    .ready_o, .rvalid_o, .rdata_o, .done_o, .count_o,
    .mem_addr_o, .mem_ce1_no, .mem_ce2_o, .mem_we_no, .mem_oe_no, .mem_ub_no, .mem_lb_no,
    .mem_dq_o, .mem_dq_oe_o, .mem_dq_i
  );

  function automatic logic [15:0] seed(input int i);
    return {8'(i) ^ 8'h3c, 8'(i)};
  endfunction

  // memory model, 256 words indexed by the low address byte
  logic [15:0] mem [256];
  logic        init_done = 1'b0;
  logic        prev_we_n = 1'b1;
  wire         chip_on = !mem_ce1_no && mem_ce2_o;
  wire         rd_drive = chip_on && !mem_oe_no && mem_we_no;
  assign mem_dq_i = rd_drive ? {mem_ub_no ? 8'h00 : mem[mem_addr_o[7:0]][15:8],
                                mem_lb_no ? 8'h00 : mem[mem_addr_o[7:0]][7:0]} : 16'hdead;

  always @(negedge clk) begin
    if (!init_done) begin
      for (int i = 0; i < 256; i++) mem[i] = seed(i);
      init_done = 1'b1;
    end
    if (!prev_we_n && mem_we_no && chip_on) begin
      if (!mem_lb_no) mem[mem_addr_o[7:0]][7:0]  = mem_dq_o[7:0];
      if (!mem_ub_no) mem[mem_addr_o[7:0]][15:8] = mem_dq_o[15:8];
    end
    prev_we_n = mem_we_no;
  end

  // pin monitor
  int we_run = 0, last_we_len = 0, oe_run = 0, last_oe_len = 0;
  int off_run = 0, last_gap = 0, clash = 0, page_moves = 0;
  logic        prev_oe_low = 1'b0;
  logic [12:0] prev_page = '0;
  always @(negedge clk) begin
    if (rst_n) begin
      if (!mem_we_no) we_run++; else if (we_run != 0) begin last_we_len = we_run; we_run = 0; end
      if (!mem_oe_no) oe_run++; else if (oe_run != 0) begin last_oe_len = oe_run; oe_run = 0; end
      if (!chip_on) off_run++; else if (off_run != 0) begin last_gap = off_run; off_run = 0; end
      if (!mem_oe_no && mem_dq_oe_o) clash++;
      if (!mem_oe_no && prev_oe_low && mem_addr_o[16:4] != prev_page) page_moves++;
      prev_oe_low = !mem_oe_no;
      prev_page   = mem_addr_o[16:4];
    end
  end

  int errors = 0, total = 0;
  task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", rq, act, exp);
    end
  endtask

  logic [15:0] rd_buf [16];
  int          nrd = 0;
  logic [4:0]  last_cnt = '0;

  task automatic run_op(input logic w, input logic [16:0] a, input logic [15:0] d,
                        input logic [1:0] b, input logic [4:0] l);
    @(negedge clk);
    while (!ready_o) @(negedge clk);
    req = 1'b1; req_we = w; req_addr = a; req_wdata = d; req_be = b; req_len = l; nrd = 0;
    @(negedge clk);
    req = 1'b0;
    while (!done_o) begin
      if (rvalid_o && nrd < 16) begin rd_buf[nrd] = rdata_o; nrd++; end
      @(negedge clk);
    end
    if (rvalid_o && nrd < 16) begin rd_buf[nrd] = rdata_o; nrd++; end
    last_cnt = count_o;
  endtask

  // {we, addr, wdata, be, expected read}
  localparam logic [51:0] VEC [10] = '{
    {1'b1, 17'h00010, 16'h1234, 2'b11, 16'h0000},
    {1'b0, 17'h00010, 16'h0000, 2'b11, 16'h1234},
    {1'b1, 17'h00010, 16'habcd, 2'b01, 16'h0000},
    {1'b0, 17'h00010, 16'h0000, 2'b11, 16'h12cd},
    {1'b1, 17'h00010, 16'h9900, 2'b10, 16'h0000},
    {1'b0, 17'h00010, 16'h0000, 2'b11, 16'h99cd},
    {1'b1, 17'h00010, 16'hffff, 2'b00, 16'h0000},
    {1'b0, 17'h00010, 16'h0000, 2'b11, 16'h99cd},
    {1'b1, 17'h1ff21, 16'h0f0f, 2'b11, 16'h0000},
    {1'b0, 17'h1ff21, 16'h0000, 2'b11, 16'h0f0f}
  };

  task automatic report();
    $display("Result: errors=%0d of %0d checks", errors, total);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run did not finish");
    report();
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 reset pins", {ready_o, mem_ce1_no, mem_ce2_o, mem_we_no, mem_oe_no, mem_ub_no, mem_lb_no, mem_dq_oe_o, rvalid_o},
        9'b1_1_0_1_1_1_1_0_0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 idle after reset", {ready_o, mem_ce1_no, mem_ce2_o, done_o}, 4'b1100);

    // vector walk: writes, lane merges, readbacks, direction changes
    for (int i = 0; i < 10; i++) begin
      run_op(VEC[i][51], VEC[i][50:34], VEC[i][33:18], VEC[i][17:16], 5'd1);
      if (!VEC[i][51]) begin
        chk("R3 R4 read data", {16'h0, rd_buf[0]}, {16'h0, VEC[i][15:0]});
        chk("R10 read count", 32'(nrd), 32'd1);
      end else begin
        chk("R10 write count", 32'(last_cnt), 32'd1);
      end
      if (i > 0 && VEC[i][51] != VEC[i-1][51])
        chk("R8 turnaround gap", last_gap, (last_gap >= TA + 1) ? last_gap : TA + 1);
      @(negedge clk);
      if (VEC[i][51]) chk("R2 strobe width", last_we_len, WL);
      else            chk("R9 access width", last_oe_len, RD);
    end

    // page burst inside one page
    run_op(1'b0, 17'h000a3, 16'h0, 2'b11, 5'd8);
    chk("R6 burst count", 32'(last_cnt), 32'd8);
    chk("R5 burst words", 32'(nrd), 32'd8);
    for (int k = 0; k < 8; k++) chk("R5 burst order", {16'h0, rd_buf[k]}, {16'h0, seed(8'ha3 + k)});
    @(negedge clk);
    chk("R9 burst oe window", last_oe_len, 8 * RD);
    chk("R5 page held", page_moves, 0);

    // truncation at page end
    run_op(1'b0, 17'h001fc, 16'h0, 2'b11, 5'd10);
    chk("R6 truncated count", 32'(last_cnt), 32'd4);
    chk("R6 truncated words", 32'(nrd), 32'd4);
    for (int k = 0; k < 4; k++) chk("R6 truncated data", {16'h0, rd_buf[k]}, {16'h0, seed(8'hfc + k)});

    // full page and zero length
    run_op(1'b0, 17'h00030, 16'h0, 2'b11, 5'd16);
    chk("R6 full page count", 32'(last_cnt), 32'd16);
    chk("R5 full page last word", {16'h0, rd_buf[15]}, {16'h0, seed(8'h3f)});
    run_op(1'b0, 17'h00055, 16'h0, 2'b11, 5'd0);
    chk("R6 zero length", 32'(last_cnt), 32'd1);
    chk("R6 zero length data", {16'h0, rd_buf[0]}, {16'h0, seed(8'h55)});
    chk("R5 no page move", page_moves, 0);

    // request while busy must be dropped
    @(negedge clk);
    while (!ready_o) @(negedge clk);
    req = 1'b1; req_we = 1'b0; req_addr = 17'h00040; req_len = 5'd1; req_be = 2'b11;
    @(negedge clk);
    req = 1'b0;
    repeat (3) @(negedge clk);
    chk("R7 busy ready", {31'h0, ready_o}, 32'd0);
    req = 1'b1; req_we = 1'b1; req_addr = 17'h00041; req_wdata = 16'hdead;
    @(negedge clk);
    req = 1'b0;
    while (!done_o) @(negedge clk);
    chk("R7 ready at done", {31'h0, ready_o}, 32'd1);
    run_op(1'b0, 17'h00041, 16'h0, 2'b11, 5'd1);
    chk("R7 dropped write", {16'h0, rd_buf[0]}, {16'h0, seed(8'h41)});

    @(negedge clk);
    chk("R1 idle standby", {ready_o, mem_ce1_no, mem_ce2_o, mem_dq_oe_o}, 4'b1100);
    chk("R8 no contention", clash, 0);
    report();
    $finish;
  end
endmodule